// File: doc/BRIEF.md
# Debounced 4x4 Keypad Scanner

This block reads a 4x4 matrix keypad. It drives one row at a time, one-hot and active high, and reads the four column lines back through a two-stage synchronizer. While no key is active the row pointer steps on each scan tick. When a single column reports a hit on a row that has been driven long enough for the synchronizer to settle, a six-state controller freezes the scan and captures the key. It then times the press with a shared 3-bit counter and issues a one-cycle strobe with the 4-bit key code. The controller holds there until every column reads zero. It then times the release with the same counter before it returns to idle, so a bouncing or held key never produces a second strobe.

Each accepted code also enters a two-entry history, newest and older, which a two-digit display can show directly. Several keys pressed together never lock the block. A hit on two columns of one row is not accepted until only one column remains. Keys pressed while another is held are ignored.

The key output is a valid-only stream. `key_valid` marks one beat, and there is no ready input and no back-pressure. A consumer must take the code on the strobe cycle. `key_code` and the history outputs stay stable between strobes, so they can also be read at any time.

Top module: `keypad_scanner`

## Requirements
- R1: A synchronous active-high reset sets `row_out` to 4'b0001, clears `key_valid`, and sets `digit_new` and `digit_old` to 0.
- R2: While idle, `row_out` stays one-hot and rotates row0, row1, row2, row3, row0 (bit 0 to bit 3, then back) one step on each clock edge where `scan_en` is high.
- R3: A key is detected only when the synchronized columns have exactly one bit set and the current row has been driven for at least two cycles since it last changed. Two or more columns set at once are never accepted.
- R4: The key code is 4*row + column, where row is the index of the set bit of `row_out` and column is the index of the set bit of `col_in`.
- R5: Each accepted press gives exactly one `key_valid` pulse, one cycle wide. The pulse comes on the fifth cycle of the press-wait state, when bit 2 of the debounce counter is first set.
- R6: From detection until the controller returns to idle, `row_out` is frozen. Keys pressed during that time produce no pulse.
- R7: After all columns read zero, the controller passes through a one-cycle release state and a five-cycle release wait before it is idle again. `row_out` stays unchanged throughout.
- R8: On each `key_valid` pulse, `digit_new` takes the new code and `digit_old` takes the previous `digit_new`.
- R9: Two keys in one row held together give no pulse. Once one of them is released, the remaining key is accepted normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| scan_en | input | 1 | Scan tick; advances the row pointer when idle |
| col_in | input | 4 | Column lines, high where a key in the driven row is closed |
| row_out | output | 4 | One-hot row drive |
| key_valid | output | 1 | One-cycle strobe for an accepted key |
| key_code | output | 4 | Code of the most recently captured key |
| digit_new | output | 4 | Newest accepted code |
| digit_old | output | 4 | Accepted code before the newest |

## Verification
All sixteen keys are pressed in turn, each one alone. This separates the row and column parts of the code map and shows that the history shifts by one entry per press. During each hold a second key is added, which shows that held-state masking is separate from release detection. Two keys on the same row are pressed together to test the single-column rule and recovery from it. Two keys on different rows show that the first row scanned wins. A release under continuous scan ticks shows that the release timing keeps the scan frozen for the full window.

// File: rtl/kp_pkg.sv
package kp_pkg;

  typedef enum logic [2:0] {
    ST_IDLE         = 3'd0,
    ST_CAPTURE      = 3'd1,
    ST_PRESS_WAIT   = 3'd2,
    ST_HELD         = 3'd3,
    ST_RELEASE      = 3'd4,
    ST_RELEASE_WAIT = 3'd5
  } kp_state_t;

endpackage

// File: rtl/kp_col_sync.sv
module kp_col_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] d_out
);

  logic [WIDTH-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= '0;
          else     chain[0] <= d_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= '0;
          else     chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign d_out = chain[STAGES-1];

endmodule

// File: rtl/kp_row_scan.sv
module kp_row_scan #(
  parameter int ROWS   = 4,
  parameter int SETTLE = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            scan_en,
  input  logic            row_stop,
  output logic [ROWS-1:0] row,
  output logic            settled
);

  localparam int SW = $clog2(SETTLE + 1);

  logic [SW-1:0] settle_cnt;
  logic          advance;

  assign advance = scan_en & ~row_stop;
  assign settled = (settle_cnt == SW'(SETTLE));

  always_ff @(posedge clk) begin
    if (rst) begin
      row        <= ROWS'(1);
      settle_cnt <= '0;
    end else if (advance) begin
      row        <= {row[ROWS-2:0], row[ROWS-1]};
      settle_cnt <= '0;
    end else if (!settled) begin
      settle_cnt <= settle_cnt + SW'(1);
    end
  end

endmodule

// File: rtl/kp_debounce_fsm.sv
module kp_debounce_fsm
  import kp_pkg::*;
#(
  parameter int ROWS     = 4,
  parameter int COLS     = 4,
  parameter int CNT_W    = 3,
  parameter int DONE_BIT = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [COLS-1:0] col_s,
  input  logic [ROWS-1:0] row,
  input  logic            settled,
  output logic            row_stop,
  output logic            detect,
  output logic            key_valid,
  output kp_state_t       state
);

  kp_state_t        nxt;
  logic [CNT_W-1:0] cnt;
  logic             cnt_run;
  logic             single_hit;

  assign single_hit = settled && (col_s != '0) && $onehot(col_s) && (row != '0);
  assign cnt_run    = (state == ST_PRESS_WAIT) || (state == ST_RELEASE_WAIT);

  always_comb begin
    nxt       = state;
    detect    = 1'b0;
    key_valid = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (single_hit) begin
          detect = 1'b1;
          nxt    = ST_CAPTURE;
        end
      end
      ST_CAPTURE:    nxt = ST_PRESS_WAIT;
      ST_PRESS_WAIT: begin
        if (cnt[DONE_BIT]) begin
          key_valid = 1'b1;
          nxt       = ST_HELD;
        end
      end
      ST_HELD:       if (col_s == '0) nxt = ST_RELEASE;
      ST_RELEASE:    nxt = ST_RELEASE_WAIT;
      ST_RELEASE_WAIT: if (cnt[DONE_BIT]) nxt = ST_IDLE;
      default:       nxt = ST_IDLE;
    endcase
  end

  assign row_stop = (state != ST_IDLE) || detect;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      state <= nxt;
      cnt   <= cnt_run ? cnt + CNT_W'(1) : '0;
    end
  end

endmodule

// File: rtl/kp_key_encode.sv
module kp_key_encode #(
  parameter int ROWS = 4,
  parameter int COLS = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          capture,
  input  logic [ROWS-1:0]               row,
  input  logic [COLS-1:0]               col_s,
  output logic [$clog2(ROWS*COLS)-1:0]  code
);

  localparam int CODE_W = $clog2(ROWS * COLS);

  logic [CODE_W-1:0] row_idx;
  logic [CODE_W-1:0] col_idx;

  always_comb begin
    row_idx = '0;
    for (int i = 0; i < ROWS; i++) if (row[i]) row_idx = CODE_W'(i);
  end

  always_comb begin
    col_idx = '0;
    for (int j = 0; j < COLS; j++) if (col_s[j]) col_idx = CODE_W'(j);
  end

  always_ff @(posedge clk) begin
    if (rst)          code <= '0;
    else if (capture) code <= CODE_W'(row_idx * CODE_W'(COLS)) + col_idx;
  end

endmodule

// File: rtl/kp_digit_hist.sv
module kp_digit_hist #(
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [CODE_W-1:0] code,
  output logic [CODE_W-1:0] newest,
  output logic [CODE_W-1:0] older
);

  always_ff @(posedge clk) begin
    if (rst) begin
      newest <= '0;
      older  <= '0;
    end else if (push) begin
      older  <= newest;
      newest <= code;
    end
  end

endmodule

// File: rtl/keypad_scanner.sv
module keypad_scanner #(
  parameter int ROWS        = 4,
  parameter int COLS        = 4,
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 3,
  parameter int DONE_BIT    = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          scan_en,
  input  logic [COLS-1:0]               col_in,
  output logic [ROWS-1:0]               row_out,
  output logic                          key_valid,
  output logic [$clog2(ROWS*COLS)-1:0]  key_code,
  output logic [$clog2(ROWS*COLS)-1:0]  digit_new,
  output logic [$clog2(ROWS*COLS)-1:0]  digit_old
);

  import kp_pkg::*;

  localparam int CODE_W = $clog2(ROWS * COLS);

  logic [COLS-1:0] col_s;
  logic            row_stop;
  logic            settled;
  logic            detect;
  kp_state_t       state;

  kp_col_sync #(.WIDTH(COLS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d_in(col_in), .d_out(col_s)
  );

  kp_row_scan #(.ROWS(ROWS), .SETTLE(SYNC_STAGES)) u_scan (
    .clk(clk), .rst(rst), .scan_en(scan_en), .row_stop(row_stop),
    .row(row_out), .settled(settled)
  );

  kp_debounce_fsm #(.ROWS(ROWS), .COLS(COLS), .CNT_W(CNT_W), .DONE_BIT(DONE_BIT)) u_fsm (
    .clk(clk), .rst(rst), .col_s(col_s), .row(row_out), .settled(settled),
    .row_stop(row_stop), .detect(detect), .key_valid(key_valid), .state(state)
  );

  kp_key_encode #(.ROWS(ROWS), .COLS(COLS)) u_enc (
    .clk(clk), .rst(rst), .capture(detect), .row(row_out), .col_s(col_s),
    .code(key_code)
  );

  kp_digit_hist #(.CODE_W(CODE_W)) u_hist (
    .clk(clk), .rst(rst), .push(key_valid), .code(key_code),
    .newest(digit_new), .older(digit_old)
  );

endmodule

// File: rtl/kp_scan_checker.sv
module kp_scan_checker
  import kp_pkg::*;
#(
  parameter int ROWS   = 4,
  parameter int COLS   = 4,
  parameter int CODE_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [ROWS-1:0]   row_out,
  input logic              key_valid,
  input logic [CODE_W-1:0] key_code,
  input logic [CODE_W-1:0] digit_new,
  input logic [CODE_W-1:0] digit_old,
  input logic [COLS-1:0]   col_s,
  input kp_state_t         state
);

  assert_row_onehot_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot(row_out));

  assert_single_col_R3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && $countones(col_s) != 1) |=> state == ST_IDLE);

  assert_pulse_width_R5: assert property (@(posedge clk) disable iff (rst)
    key_valid |=> !key_valid);

  assert_pulse_to_held_R5: assert property (@(posedge clk) disable iff (rst)
    key_valid |=> state == ST_HELD);

  assert_row_frozen_R6: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE) |=> $stable(row_out));

  assert_release_seen_R7: assert property (@(posedge clk) disable iff (rst)
    (state == ST_HELD && col_s == '0) |=> state == ST_RELEASE);

  assert_history_shift_R8: assert property (@(posedge clk) disable iff (rst)
    key_valid |=> (digit_new == $past(key_code)) && (digit_old == $past(digit_new)));

  assert_history_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !key_valid |=> $stable(digit_new) && $stable(digit_old));

endmodule

bind keypad_scanner kp_scan_checker #(.ROWS(ROWS), .COLS(COLS), .CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst(rst), .row_out(row_out), .key_valid(key_valid),
  .key_code(key_code), .digit_new(digit_new), .digit_old(digit_old),
  .col_s(col_s), .state(state)
);

// File: tb/keypad_scanner_bench.sv
`timescale 1ns/1ps
module keypad_scanner_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  col_in;
  logic [3:0]  row_out;
  logic        key_valid;
  logic [3:0]  key_code, digit_new, digit_old;
  logic        scan_en;
  logic [15:0] pressed = '0;
  int          mode = 0;
  int          ph = 0;
  int          vcount = 0;
  int          wide = 0;
  int          last_code = 0;
  logic        prev_kv = 1'b0;
  int          tests = 0;
  int          fails = 0;
  bit          done = 0;

  always #4 clk = ~clk;

  assign scan_en = (mode == 2) || (mode == 1 && ph == 0);

  always_comb begin
    col_in = '0;
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 4; c++)
        if (row_out[r] && pressed[r*4+c]) col_in[c] = 1'b1;
  end

  keypad_scanner u_keypad_scanner (
    .clk(clk), .rst(rst), .scan_en(scan_en), .col_in(col_in),
    .row_out(row_out), .key_valid(key_valid), .key_code(key_code),
    .digit_new(digit_new), .digit_old(digit_old)
  );

  always @(negedge clk) begin
    ph <= (ph + 1) % 4;
    if (!rst) begin
      if (key_valid) begin
        vcount    <= vcount + 1;
        last_code <= int'(key_code);
        if (prev_kv) wide <= wide + 1;
      end
      prev_kv <= key_valid;
    end
  end

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_valid(input int v0, input int maxc, output bit got);
    got = 0;
    for (int i = 0; i < maxc && !got; i++) begin
      step();
      if (vcount != v0) got = 1;
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog expired actual=0 expected=1");
    summary();
  end

  initial begin
    bit got;
    int v0, prev, r0;
    bit stable;

    repeat (3) step();
    rst = 1'b0;
    step();
    // R1: reset state
    chk(row_out == 4'b0001, "R1 row_out after reset", int'(row_out), 1);
    chk(key_valid == 1'b0, "R1 key_valid after reset", int'(key_valid), 0);
    chk(digit_new == 4'd0, "R1 digit_new after reset", int'(digit_new), 0);
    chk(digit_old == 4'd0, "R1 digit_old after reset", int'(digit_old), 0);

    // R2: rotation on every scan tick while idle
    mode = 2;
    for (int i = 1; i <= 8; i++) begin
      step();
      chk(row_out == 4'(1 << (i % 4)), "R2 row rotation", int'(row_out), 1 << (i % 4));
    end

    // Exhaustive single-key sweep: R4, R5, R6, R7, R8
    mode = 1;
    prev = 0;
    for (int k = 0; k < 16; k++) begin
      v0 = vcount;
      pressed = 16'(1 << k);
      wait_valid(v0, 300, got);
      chk(got, "R5 press accepted", int'(got), 1);
      step();
      chk(last_code == k, "R4 key code", last_code, k);
      chk(row_out == 4'(1 << (k / 4)), "R6 scan frozen on key row", int'(row_out), 1 << (k / 4));
      r0 = int'(row_out);
      pressed[(k + 5) % 16] = 1'b1;
      stable = 1;
      repeat (30) begin
        step();
        if (int'(row_out) != r0) stable = 0;
      end
      chk(stable, "R6 row stable while held", int'(stable), 1);
      chk(vcount == v0 + 1, "R6 extra key ignored", vcount - v0, 1);
      pressed = '0;
      repeat (40) step();
      chk(vcount == v0 + 1, "R7 no retrigger on release", vcount - v0, 1);
      chk(digit_new == 4'(k), "R8 newest digit", int'(digit_new), k);
      chk(digit_old == 4'(prev), "R8 older digit", int'(digit_old), prev);
      prev = k;
    end
    chk(wide == 0, "R5 pulse one cycle wide", wide, 0);

    // R9 / R3: two columns in one row
    v0 = vcount;
    pressed = 16'b0000_0000_0011_0000;
    repeat (150) step();
    chk(vcount == v0, "R3 two-column hit rejected", vcount - v0, 0);
    pressed[5] = 1'b0;
    wait_valid(v0, 300, got);
    chk(got, "R9 recovers after release", int'(got), 1);
    step();
    chk(last_code == 4, "R9 remaining key code", last_code, 4);
    pressed = '0;
    repeat (40) step();

    // Two keys on different rows: exactly one accepted
    v0 = vcount;
    pressed = '0;
    pressed[2] = 1'b1;
    pressed[13] = 1'b1;
    wait_valid(v0, 300, got);
    step();
    chk(got && (last_code == 2 || last_code == 13), "R3 one of two rows accepted", last_code, 2);
    repeat (40) step();
    chk(vcount == v0 + 1, "R6 second row ignored while held", vcount - v0, 1);
    pressed = '0;
    repeat (40) step();

    // R7: release window under continuous scan ticks
    v0 = vcount;
    pressed = '0;
    pressed[7] = 1'b1;
    wait_valid(v0, 300, got);
    chk(got, "R5 press accepted before release test", int'(got), 1);
    repeat (5) step();
    mode = 2;
    r0 = int'(row_out);
    pressed = '0;
    stable = 1;
    repeat (8) begin
      step();
      if (int'(row_out) != r0) stable = 0;
    end
    chk(stable, "R7 row frozen through release wait", int'(stable), 1);
    repeat (20) step();
    chk(int'(row_out) != r0, "R2 scan resumes after release", int'(row_out), r0);
    chk(vcount == v0 + 1, "R7 single pulse across release", vcount - v0, 1);

    summary();
  end

endmodule